// File: doc/BRIEF.md
# Reservation Station Bank with Result Snooping

This block is a bank of reservation-station entries in front of one non-pipelined execution unit. Each issued operation arrives with an operation code and two source operands. For each source, the issuer supplies either a value or the nonzero tag of the station that will produce it. The bank places the operation in a free entry. It then watches the single result broadcast bus, and any waiting source whose stored tag equals the broadcast tag takes the broadcast data. Because operands wait on producer tags rather than register names, register renaming happens without any extra logic.

An entry whose two sources are both present is offered to the execution unit through a valid/ready dispatch port, together with its own tag. The unit later broadcasts its result under that tag. That broadcast releases the entry and also feeds any other station waiting on it. When every entry is occupied, the issue port is held back. This is a structural stall.

Each entry has a fixed tag equal to `BASE_TAG` plus its index. Tag zero is reserved to mean "value present".

Top module: `rsb_bank`

## Requirements
- R1: After reset, `issue_ready_o` is 1 and `disp_valid_o` is 0.
- R2: An operation issued with both source tags equal to zero is offered on the dispatch port in the next cycle, with its op code and both values unchanged.
- R3: A waiting source captures `bcast_data_i` and becomes present only when `bcast_valid_i` is high and `bcast_tag_i` equals its stored tag. Broadcasts with any other tag leave it waiting and leave its value untouched.
- R4: An entry is never dispatched while either of its source tags is nonzero.
- R5: While all entries are busy, `issue_ready_o` is 0, and an `issue_valid_i` pulse is ignored. No entry is written, and no extra operation appears later.
- R6: When an executing entry's own tag (`BASE_TAG` + index) is broadcast, that entry becomes free, and `issue_ready_o` is 1 from the next cycle.
- R7: If a source is issued with tag T in the same cycle that tag T is broadcast, the entry stores the broadcast data and treats that source as present.
- R8: When several entries are ready, the lowest-index entry is dispatched first. Its tag `disp_tag_o` equals `BASE_TAG` + index.
- R9: At most one entry is executing at any time. `disp_valid_o` stays 0 from the accepted dispatch until that entry's result is broadcast, even if other entries are ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | Issue request |
| issue_ready_o | output | 1 | A free entry exists |
| issue_op_i | input | OP_W | Operation code |
| issue_vj_i | input | DATA_W | First source value (used when tag is 0) |
| issue_qj_i | input | TAG_W | First source producer tag, 0 = present |
| issue_vk_i | input | DATA_W | Second source value (used when tag is 0) |
| issue_qk_i | input | TAG_W | Second source producer tag, 0 = present |
| bcast_valid_i | input | 1 | Result broadcast valid |
| bcast_tag_i | input | TAG_W | Tag of the producing station |
| bcast_data_i | input | DATA_W | Broadcast result |
| disp_valid_o | output | 1 | A ready entry is offered to the unit |
| disp_ready_i | input | 1 | Unit accepts the offered entry |
| disp_op_o | output | OP_W | Offered op code |
| disp_vj_o | output | DATA_W | Offered first operand |
| disp_vk_o | output | DATA_W | Offered second operand |
| disp_tag_o | output | TAG_W | Tag the unit must broadcast with its result |

## Verification
The bench builds the bank in its three-entry form with 64-bit data, 4-bit tags and entry tags 1 to 3. This lets it fill the bank completely and exercise the structural stall. It also lets two entries become ready behind an executing one, so the lowest-index choice and the single-execution rule are both visible at the ports. Producer tags 5, 6, 7 and 9 stand for stations in other banks. They drive matching, non-matching and same-cycle broadcasts without ever releasing an entry of this bank.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  typedef enum logic [1:0] {
    ST_FREE = 2'd0,
    ST_WAIT = 2'd1,
    ST_EXEC = 2'd2
  } rs_state_e;
endpackage

// File: rtl/rsb_pick.sv
module rsb_pick #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  logic found;

  always_comb begin
    gnt_o = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !found) begin
        gnt_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/rsb_src.sv
module rsb_src #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned TAG_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] v_i,
  input  logic [TAG_W-1:0]  q_i,
  input  logic              bc_valid_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_data_i,
  output logic [DATA_W-1:0] v_o,
  output logic              rdy_o
);
  logic [DATA_W-1:0] v_q;
  logic [TAG_W-1:0]  q_q;
  logic              hit_new, hit_old;

  // same-cycle bypass for a tag arriving with the issue
  assign hit_new = bc_valid_i && (q_i != '0) && (bc_tag_i == q_i);
  assign hit_old = bc_valid_i && (q_q != '0) && (bc_tag_i == q_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0;
      q_q <= '0;
    end else if (load_i) begin
      if (hit_new) begin
        v_q <= bc_data_i;
        q_q <= '0;
      end else begin
        v_q <= v_i;
        q_q <= q_i;
      end
    end else if (hit_old) begin
      v_q <= bc_data_i;
      q_q <= '0;
    end
  end

  assign v_o   = v_q;
  assign rdy_o = (q_q == '0);
endmodule

// File: rtl/rsb_entry.sv
module rsb_entry
  import rsb_pkg::*;
#(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned TAG_W   = 4,
  parameter int unsigned OP_W    = 4,
  parameter int unsigned OWN_TAG = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] vj_i,
  input  logic [TAG_W-1:0]  qj_i,
  input  logic [DATA_W-1:0] vk_i,
  input  logic [TAG_W-1:0]  qk_i,
  input  logic              bc_valid_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_data_i,
  input  logic              fire_i,
  output logic              busy_o,
  output logic              exec_o,
  output logic              ready_o,
  output logic              opnd_rdy_o,
  output logic [OP_W-1:0]   op_o,
  output logic [DATA_W-1:0] vj_o,
  output logic [DATA_W-1:0] vk_o
);
  rs_state_e         state_q, state_d;
  logic [OP_W-1:0]   op_q;
  logic              rdy_j, rdy_k, own_done;

  assign own_done = bc_valid_i && (bc_tag_i == TAG_W'(OWN_TAG));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FREE: if (load_i)   state_d = ST_WAIT;
      ST_WAIT: if (fire_i)   state_d = ST_EXEC;
      ST_EXEC: if (own_done) state_d = ST_FREE;
      default:               state_d = ST_FREE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FREE;
      op_q    <= '0;
    end else begin
      state_q <= state_d;
      if (load_i) op_q <= op_i;
    end
  end

  rsb_src #(.DATA_W(DATA_W), .TAG_W(TAG_W)) i_src_j (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_i),
    .v_i       (vj_i),
    .q_i       (qj_i),
    .bc_valid_i(bc_valid_i),
    .bc_tag_i  (bc_tag_i),
    .bc_data_i (bc_data_i),
    .v_o       (vj_o),
    .rdy_o     (rdy_j)
  );

  rsb_src #(.DATA_W(DATA_W), .TAG_W(TAG_W)) i_src_k (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_i),
    .v_i       (vk_i),
    .q_i       (qk_i),
    .bc_valid_i(bc_valid_i),
    .bc_tag_i  (bc_tag_i),
    .bc_data_i (bc_data_i),
    .v_o       (vk_o),
    .rdy_o     (rdy_k)
  );

  assign busy_o     = (state_q != ST_FREE);
  assign exec_o     = (state_q == ST_EXEC);
  assign opnd_rdy_o = rdy_j && rdy_k;
  assign ready_o    = (state_q == ST_WAIT) && opnd_rdy_o;
  assign op_o       = op_q;
endmodule

// File: rtl/rsb_bank.sv
module rsb_bank #(
  parameter int unsigned NUM_ENTRIES = 3,
  parameter int unsigned DATA_W      = 64,
  parameter int unsigned TAG_W       = 4,
  parameter int unsigned OP_W        = 4,
  parameter int unsigned BASE_TAG    = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_valid_i,
  output logic              issue_ready_o,
  input  logic [OP_W-1:0]   issue_op_i,
  input  logic [DATA_W-1:0] issue_vj_i,
  input  logic [TAG_W-1:0]  issue_qj_i,
  input  logic [DATA_W-1:0] issue_vk_i,
  input  logic [TAG_W-1:0]  issue_qk_i,
  input  logic              bcast_valid_i,
  input  logic [TAG_W-1:0]  bcast_tag_i,
  input  logic [DATA_W-1:0] bcast_data_i,
  output logic              disp_valid_o,
  input  logic              disp_ready_i,
  output logic [OP_W-1:0]   disp_op_o,
  output logic [DATA_W-1:0] disp_vj_o,
  output logic [DATA_W-1:0] disp_vk_o,
  output logic [TAG_W-1:0]  disp_tag_o
);
  localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  logic [NUM_ENTRIES-1:0] busy_vec, exec_vec, ready_vec, opnd_rdy_vec;
  logic [NUM_ENTRIES-1:0] alloc_gnt, disp_gnt, load_vec, fire_vec;
  logic                   free_any, ready_any, exec_any;
  logic [OP_W-1:0]        op_arr [NUM_ENTRIES];
  logic [DATA_W-1:0]      vj_arr [NUM_ENTRIES];
  logic [DATA_W-1:0]      vk_arr [NUM_ENTRIES];
  logic [IDX_W-1:0]       disp_idx;

  rsb_pick #(.N(NUM_ENTRIES)) i_alloc_pick (
    .req_i(~busy_vec),
    .gnt_o(alloc_gnt),
    .any_o(free_any)
  );

  rsb_pick #(.N(NUM_ENTRIES)) i_disp_pick (
    .req_i(ready_vec),
    .gnt_o(disp_gnt),
    .any_o(ready_any)
  );

  assign issue_ready_o = free_any;
  assign load_vec      = alloc_gnt & {NUM_ENTRIES{issue_valid_i}};
  assign exec_any      = |exec_vec;
  // non-pipelined unit: hold dispatch until the executing entry reports back
  assign disp_valid_o  = ready_any && !exec_any;
  assign fire_vec      = disp_gnt & {NUM_ENTRIES{disp_valid_o && disp_ready_i}};

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
    rsb_entry #(
      .DATA_W (DATA_W),
      .TAG_W  (TAG_W),
      .OP_W   (OP_W),
      .OWN_TAG(BASE_TAG + g)
    ) i_entry (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load_vec[g]),
      .op_i      (issue_op_i),
      .vj_i      (issue_vj_i),
      .qj_i      (issue_qj_i),
      .vk_i      (issue_vk_i),
      .qk_i      (issue_qk_i),
      .bc_valid_i(bcast_valid_i),
      .bc_tag_i  (bcast_tag_i),
      .bc_data_i (bcast_data_i),
      .fire_i    (fire_vec[g]),
      .busy_o    (busy_vec[g]),
      .exec_o    (exec_vec[g]),
      .ready_o   (ready_vec[g]),
      .opnd_rdy_o(opnd_rdy_vec[g]),
      .op_o      (op_arr[g]),
      .vj_o      (vj_arr[g]),
      .vk_o      (vk_arr[g])
    );
  end

  always_comb begin
    disp_op_o = '0;
    disp_vj_o = '0;
    disp_vk_o = '0;
    disp_idx  = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (disp_gnt[i]) begin
        disp_op_o = op_arr[i];
        disp_vj_o = vj_arr[i];
        disp_vk_o = vk_arr[i];
        disp_idx  = IDX_W'(i);
      end
    end
  end

  assign disp_tag_o = TAG_W'(BASE_TAG) + TAG_W'(disp_idx);
endmodule

// File: rtl/rsb_checker.sv
module rsb_checker #(
  parameter int unsigned NUM_ENTRIES = 3,
  parameter int unsigned TAG_W       = 4,
  parameter int unsigned BASE_TAG    = 1
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   issue_valid_i,
  input logic                   issue_ready_o,
  input logic                   disp_valid_o,
  input logic [TAG_W-1:0]       disp_tag_o,
  input logic                   bcast_valid_i,
  input logic [TAG_W-1:0]       bcast_tag_i,
  input logic [NUM_ENTRIES-1:0] busy_vec,
  input logic [NUM_ENTRIES-1:0] exec_vec,
  input logic [NUM_ENTRIES-1:0] opnd_rdy_vec
);
  a_r9_single_exec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(exec_vec) <= 1);

  a_r5_no_alloc_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_i && !issue_ready_o) |=> ($countones(busy_vec) <= $past($countones(busy_vec))));

  a_r8_tag_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o |-> ((disp_tag_o >= TAG_W'(BASE_TAG)) &&
                      (disp_tag_o <  TAG_W'(BASE_TAG + NUM_ENTRIES))));

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_chk
    a_r4_start_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(exec_vec[g]) |-> $past(opnd_rdy_vec[g]));

    a_r6_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (exec_vec[g] && bcast_valid_i && (bcast_tag_i == TAG_W'(BASE_TAG + g))) |=> !busy_vec[g]);
  end
endmodule

bind rsb_bank rsb_checker #(
  .NUM_ENTRIES(NUM_ENTRIES),
  .TAG_W      (TAG_W),
  .BASE_TAG   (BASE_TAG)
) i_rsb_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .issue_valid_i(issue_valid_i),
  .issue_ready_o(issue_ready_o),
  .disp_valid_o (disp_valid_o),
  .disp_tag_o   (disp_tag_o),
  .bcast_valid_i(bcast_valid_i),
  .bcast_tag_i  (bcast_tag_i),
  .busy_vec     (busy_vec),
  .exec_vec     (exec_vec),
  .opnd_rdy_vec (opnd_rdy_vec)
);

// File: tb/test_rsb_bank.sv
`timescale 1ns/1ps
module test_rsb_bank;
  localparam int DW = 64;
  localparam int TW = 4;
  localparam int OW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          issue_valid = 1'b0;
  logic          issue_ready;
  logic [OW-1:0] issue_op = '0;
  logic [DW-1:0] issue_vj = '0, issue_vk = '0;
  logic [TW-1:0] issue_qj = '0, issue_qk = '0;
  logic          bc_valid = 1'b0;
  logic [TW-1:0] bc_tag = '0;
  logic [DW-1:0] bc_data = '0;
  logic          disp_valid;
  logic          disp_ready = 1'b0;
  logic [OW-1:0] disp_op;
  logic [DW-1:0] disp_vj, disp_vk;
  logic [TW-1:0] disp_tag;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rsb_bank #(.NUM_ENTRIES(3), .DATA_W(DW), .TAG_W(TW), .OP_W(OW), .BASE_TAG(1)) i_rsb_bank (
    .clk_i(clk), .rst_ni(rst_n),
    .issue_valid_i(issue_valid), .issue_ready_o(issue_ready),
    .issue_op_i(issue_op), .issue_vj_i(issue_vj), .issue_qj_i(issue_qj),
    .issue_vk_i(issue_vk), .issue_qk_i(issue_qk),
    .bcast_valid_i(bc_valid), .bcast_tag_i(bc_tag), .bcast_data_i(bc_data),
    .disp_valid_o(disp_valid), .disp_ready_i(disp_ready),
    .disp_op_o(disp_op), .disp_vj_o(disp_vj), .disp_vk_o(disp_vk), .disp_tag_o(disp_tag)
  );

  typedef struct packed {
    logic [OW-1:0] op;
    logic [DW-1:0] vj;
    logic [DW-1:0] vk;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{4'h1, 64'h0000_0000_0000_0011, 64'h0000_0000_0000_0022},
    '{4'h7, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
    '{4'hA, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321},
    '{4'hF, 64'h8000_0000_0000_0001, 64'h5555_AAAA_5555_AAAA}
  };

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // advance one cycle; return 1 ns after the falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic set_issue(input logic [OW-1:0] op, input logic [DW-1:0] vj, input logic [TW-1:0] qj,
                           input logic [DW-1:0] vk, input logic [TW-1:0] qk);
    issue_valid = 1'b1;
    issue_op = op; issue_vj = vj; issue_qj = qj; issue_vk = vk; issue_qk = qk;
  endtask

  task automatic bcast(input logic [TW-1:0] tag, input logic [DW-1:0] data);
    bc_valid = 1'b1; bc_tag = tag; bc_data = data;
    tick();
    bc_valid = 1'b0;
  endtask

  task automatic fire();
    disp_ready = 1'b1;
    tick();
    disp_ready = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    chk("R1 issue_ready", issue_ready, 1);
    chk("R1 disp_valid", disp_valid, 0);
    rst_n = 1'b1;
    tick();
    chk("R1 issue_ready after release", issue_ready, 1);
    chk("R1 disp_valid after release", disp_valid, 0);

    // R2 / R6: table of independent operations
    for (int i = 0; i < 4; i++) begin
      set_issue(VECS[i].op, VECS[i].vj, 0, VECS[i].vk, 0);
      tick();
      issue_valid = 1'b0;
      chk("R2 disp_valid", disp_valid, 1);
      chk("R2 op", disp_op, VECS[i].op);
      chk("R2 vj", disp_vj, VECS[i].vj);
      chk("R2 vk", disp_vk, VECS[i].vk);
      chk("R8 tag of entry 0", disp_tag, 1);
      fire();
      chk("R9 no dispatch while executing", disp_valid, 0);
      bcast(1, 64'hDEAD);
      chk("R6 freed", issue_ready, 1);
      chk("R6 nothing pending", disp_valid, 0);
    end

    // R3 / R4: wait on tag 5
    set_issue(4'h3, 64'h0, 5, 64'h77, 0);
    tick();
    issue_valid = 1'b0;
    chk("R4 waiting not dispatched", disp_valid, 0);
    bcast(6, 64'hBAD0_BAD0);
    chk("R3 other tag ignored", disp_valid, 0);
    bcast(5, 64'hC0DE_0005);
    chk("R3 captured ready", disp_valid, 1);
    chk("R3 captured vj", disp_vj, 64'hC0DE_0005);
    chk("R3 vk kept", disp_vk, 64'h77);
    fire();
    bcast(1, 64'h0);

    // R7: same-cycle issue and broadcast
    set_issue(4'h4, 64'h0, 7, 64'h0, 7);
    bc_valid = 1'b1; bc_tag = 7; bc_data = 64'hB1B1_0007;
    tick();
    issue_valid = 1'b0; bc_valid = 1'b0;
    chk("R7 bypass ready", disp_valid, 1);
    chk("R7 bypass vj", disp_vj, 64'hB1B1_0007);
    chk("R7 bypass vk", disp_vk, 64'hB1B1_0007);
    fire();
    bcast(1, 64'h0);

    // R5 / R8 / R9: fill the bank
    set_issue(4'h5, 64'h0, 9, 64'hA2, 0);    // entry 0, waits on 9
    tick();
    set_issue(4'h6, 64'hB1, 0, 64'hB2, 0);   // entry 1, ready
    tick();
    set_issue(4'h8, 64'hC1, 0, 64'hC2, 0);   // entry 2, ready
    tick();
    chk("R5 full stall", issue_ready, 0);
    chk("R8 lowest ready valid", disp_valid, 1);
    chk("R8 lowest ready tag", disp_tag, 2);
    chk("R8 lowest ready op", disp_op, 4'h6);
    set_issue(4'h9, 64'hD1, 0, 64'hD2, 0);   // must be ignored
    disp_ready = 1'b1;
    tick();
    issue_valid = 1'b0; disp_ready = 1'b0;
    chk("R9 held while executing", disp_valid, 0);
    bcast(9, 64'hA1A1);
    chk("R9 held with two ready", disp_valid, 0);
    chk("R5 still full", issue_ready, 0);
    bcast(2, 64'h0);
    chk("R6 released by own tag", issue_ready, 1);
    chk("R8 next valid", disp_valid, 1);
    chk("R8 lowest index tag", disp_tag, 1);
    chk("R3 captured before dispatch", disp_vj, 64'hA1A1);
    fire();
    bcast(1, 64'h0);
    chk("R8 last tag", disp_tag, 3);
    chk("R5 entry kept op", disp_op, 4'h8);
    chk("R5 entry kept vj", disp_vj, 64'hC1);
    fire();
    bcast(3, 64'h0);
    chk("R5 ignored issue absent", disp_valid, 0);
    chk("R6 all free", issue_ready, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule